// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This unit watches a bank of asynchronous external event lines. Each line is brought into the clock domain and checked for rising and falling transitions. Transitions that software has enabled are latched as pending flags. Rising transitions and falling transitions are kept in two separate pending registers, and each is cleared by writing 1 to the bit.

A level interrupt output stays high while any pending flag belongs to a line whose interrupt is enabled. A separate per-line event output gives a one-cycle pulse for each detected transition on lines whose event output is enabled. Software can raise a rising-side pending flag itself through a trigger register.

A build-time mask fixes which lines exist. Bits for absent lines are tied to zero in every register. Software can find the populated lines by writing all ones to the rising-enable register and reading it back.

Top module: `edge_irq_unit`

## Requirements
- R1: Line n of `extIn` maps to bit n of every per-line register and of `evtOut`. The register offsets are: rising enable 0x00, falling enable 0x04, software trigger 0x08, rising pending 0x0C, falling pending 0x10, interrupt enable 0x80, event enable 0x84. A 1 in an enable register turns the function on for that line.
- R2: A rising transition on a line whose rising-enable bit is 1 sets that line's bit in the rising pending register, visible after the third rising clock edge that follows the input change. Two flops synchronise the input and one flop holds the previous value. With the enable bit at 0, the same transition sets nothing.
- R3: A falling transition on a line whose falling-enable bit is 1 sets that line's bit in the falling pending register, with the same latency as R2. With both enable bits set, each transition sets its own register.
- R4: Writing 1 to a bit of either pending register clears that bit on the next clock edge. Writing 0 leaves the bit unchanged.
- R5: If a qualified transition and a clearing write hit the same pending bit on the same clock edge, the bit ends up set.
- R6: Bits of lines absent from `IMPL_LINES` read 0 in every register whatever is written, and those lines never raise a flag or an event. Writing all ones to offset 0x00 and reading it back returns exactly `IMPL_LINES`.
- R7: `irqOut` is high exactly while some line has its interrupt-enable bit set and a 1 in either pending register.
- R8: Writing 1 to a trigger bit sets that line's rising pending bit on the same clock edge, so it is visible in the following cycle. This works whatever the rising-enable bit holds. The trigger bit reads 1 until that rising pending bit is cleared by a write.
- R9: `evtOut[n]` is high for one cycle, the cycle in which the matching pending bit first shows, for every qualified transition on a line whose event-enable bit is 1. It is never high for a line whose event-enable bit was 0.
- R10: Reads of any offset not listed in R1 return 0, and writes to such offsets change nothing.
- R11: A low `rstN` at a rising clock edge clears every register, synchroniser and output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| extIn | input | 32 | Asynchronous external event lines |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 8 | Byte offset of the register accessed |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Active-high level interrupt |
| evtOut | output | 32 | Per-line one-cycle event pulses |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the exact edge where a fresh transition comes out of the synchroniser. The write must arrive three clock edges after the input change, and nothing in the interface shows when detection will happen. The directed stimulus changes the line on a falling clock edge, counts two rising edges, and then presents the clearing write so that both meet on the third. A long random phase then sparsely toggles lines and mixes writes to all offsets, including unmapped ones. A behavioural per-line model in the bench is compared with the design every cycle.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LINE_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RISE_EN   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SW_TRIG   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE_PEND = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FALL_PEND = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN    = 8'h84;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic              wrRiseEn;
    logic              wrFallEn;
    logic              wrSwTrig;
    logic              clrRise;
    logic              clrFall;
    logic              wrIrqEn;
    logic              wrEvtEn;
    logic [LINE_W-1:0] data;
  } strobe_t;

  // register contents handed back for read-out
  typedef struct packed {
    logic [LINE_W-1:0] riseEn;
    logic [LINE_W-1:0] fallEn;
    logic [LINE_W-1:0] swTrig;
    logic [LINE_W-1:0] risePend;
    logic [LINE_W-1:0] fallPend;
    logic [LINE_W-1:0] irqEn;
    logic [LINE_W-1:0] evtEn;
  } regView_t;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs import edge_irq_pkg::*; (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LINE_W-1:0] regWdata,
  input  regView_t          view,
  output strobe_t           strobe,
  output logic [LINE_W-1:0] regRdata
);
  always_comb begin
    strobe      = '0;
    strobe.data = regWdata;
    if (regWrEn) begin
      unique case (regAddr)
        OFS_RISE_EN:   strobe.wrRiseEn = 1'b1;
        OFS_FALL_EN:   strobe.wrFallEn = 1'b1;
        OFS_SW_TRIG:   strobe.wrSwTrig = 1'b1;
        OFS_RISE_PEND: strobe.clrRise  = 1'b1;
        OFS_FALL_PEND: strobe.clrFall  = 1'b1;
        OFS_IRQ_EN:    strobe.wrIrqEn  = 1'b1;
        OFS_EVT_EN:    strobe.wrEvtEn  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_RISE_EN:   regRdata = view.riseEn;
      OFS_FALL_EN:   regRdata = view.fallEn;
      OFS_SW_TRIG:   regRdata = view.swTrig;
      OFS_RISE_PEND: regRdata = view.risePend;
      OFS_FALL_PEND: regRdata = view.fallPend;
      OFS_IRQ_EN:    regRdata = view.irqEn;
      OFS_EVT_EN:    regRdata = view.evtEn;
      default:       regRdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_irq_core.sv
module edge_irq_core import edge_irq_pkg::*; #(
  parameter logic [LINE_W-1:0] IMPL_LINES  = 32'hC03F_FFFF,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] extIn,
  input  strobe_t           strobe,
  output regView_t          view,
  output logic              irqOut,
  output logic [LINE_W-1:0] evtOut
);
  logic [LINE_W-1:0] syncNow, prevQ;
  logic [LINE_W-1:0] riseEnQ, fallEnQ, swTrigQ, risePendQ, fallPendQ, irqEnQ, evtEnQ;
  logic [LINE_W-1:0] riseDet, fallDet, swSet, clrRiseMask, clrFallMask, riseSet;

  edge_irq_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(extIn), .syncOut(syncNow)
  );

  assign riseDet     = syncNow & ~prevQ & riseEnQ;
  assign fallDet     = ~syncNow & prevQ & fallEnQ;
  assign swSet       = strobe.wrSwTrig ? (strobe.data & IMPL_LINES) : '0;
  assign clrRiseMask = strobe.clrRise ? strobe.data : '0;
  assign clrFallMask = strobe.clrFall ? strobe.data : '0;
  assign riseSet     = riseDet | swSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ     <= '0;
      riseEnQ   <= '0;
      fallEnQ   <= '0;
      swTrigQ   <= '0;
      risePendQ <= '0;
      fallPendQ <= '0;
      irqEnQ    <= '0;
      evtEnQ    <= '0;
      evtOut    <= '0;
    end else begin
      prevQ <= syncNow;
      if (strobe.wrRiseEn) riseEnQ <= strobe.data & IMPL_LINES;
      if (strobe.wrFallEn) fallEnQ <= strobe.data & IMPL_LINES;
      if (strobe.wrIrqEn)  irqEnQ  <= strobe.data & IMPL_LINES;
      if (strobe.wrEvtEn)  evtEnQ  <= strobe.data & IMPL_LINES;
      // a fresh set beats a clear on the same edge
      risePendQ <= (risePendQ & ~clrRiseMask) | riseSet;
      fallPendQ <= (fallPendQ & ~clrFallMask) | fallDet;
      swTrigQ   <= (swTrigQ & ~clrRiseMask) | swSet;
      evtOut    <= (riseDet | fallDet) & evtEnQ;
    end
  end

  assign irqOut = |((risePendQ | fallPendQ) & irqEnQ);

  assign view.riseEn   = riseEnQ;
  assign view.fallEn   = fallEnQ;
  assign view.swTrig   = swTrigQ;
  assign view.risePend = risePendQ;
  assign view.fallPend = fallPendQ;
  assign view.irqEn    = irqEnQ;
  assign view.evtEn    = evtEnQ;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrRise |=> ((risePendQ & $past(strobe.data & ~riseSet)) == '0)); // R4
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (riseSet != '0) |=> ((risePendQ & $past(riseSet)) == $past(riseSet))); // R5
  AST_SW_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (swSet != '0) |=> ((swTrigQ & risePendQ & $past(swSet)) == $past(swSet))); // R8
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((risePendQ | fallPendQ | evtOut) & ~IMPL_LINES) == '0); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobe.clrRise && !strobe.clrFall && !strobe.wrIrqEn) |=> irqOut); // R7
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (evtEnQ == '0 && !strobe.wrEvtEn) |=> (evtOut == '0)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRiseEn, strobe.wrFallEn, strobe.wrSwTrig, strobe.clrRise,
              strobe.clrFall, strobe.wrIrqEn, strobe.wrEvtEn})); // R10
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit import edge_irq_pkg::*; #(
  parameter logic [LINE_W-1:0] IMPL_LINES  = 32'hC03F_FFFF,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] extIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LINE_W-1:0] regWdata,
  output logic [LINE_W-1:0] regRdata,
  output logic              irqOut,
  output logic [LINE_W-1:0] evtOut
);
  strobe_t  strobe;
  regView_t view;

  edge_irq_regs uRegs (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .view(view), .strobe(strobe), .regRdata(regRdata)
  );

  edge_irq_core #(.IMPL_LINES(IMPL_LINES), .SYNC_STAGES(SYNC_STAGES)) uCore (
    .clk(clk), .rstN(rstN), .extIn(extIn), .strobe(strobe),
    .view(view), .irqOut(irqOut), .evtOut(evtOut)
  );
endmodule

// File: tb/sim_edge_irq_unit.sv
`timescale 1ns/1ps
module sim_edge_irq_unit;
  localparam logic [31:0] IMPL = 32'hC03F_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] extIn = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, evtOut;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit checkOn = 0;

  always #4 clk = ~clk;

  edge_irq_unit u0 (
    .clk(clk), .rstN(rstN), .extIn(extIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .evtOut(evtOut)
  );

  // behavioural reference, one line at a time
  bit m1 [32], m2 [32], mPrev [32];
  bit mRe [32], mFe [32], mSw [32], mRp [32], mFp [32], mIe [32], mEe [32], mEvt [32];

  always @(posedge clk) begin
    for (int i = 0; i < 32; i++) begin
      bit present, rEdge, fEdge, wr, swHit, rClr, fClr;
      present = IMPL[i];
      if (!rstN) begin
        m1[i] = 0; m2[i] = 0; mPrev[i] = 0; mRe[i] = 0; mFe[i] = 0; mSw[i] = 0;
        mRp[i] = 0; mFp[i] = 0; mIe[i] = 0; mEe[i] = 0; mEvt[i] = 0;
      end else begin
        rEdge = present && mRe[i] && m2[i] && !mPrev[i];
        fEdge = present && mFe[i] && !m2[i] && mPrev[i];
        wr    = regWrEn && regWdata[i];
        swHit = wr && present && regAddr == 8'h08;
        rClr  = wr && regAddr == 8'h0C;
        fClr  = wr && regAddr == 8'h10;
        mEvt[i] = (rEdge || fEdge) && mEe[i];
        mRp[i]  = rEdge || swHit || (mRp[i] && !rClr);
        mFp[i]  = fEdge || (mFp[i] && !fClr);
        mSw[i]  = swHit || (mSw[i] && !rClr);
        if (regWrEn) begin
          case (regAddr)
            8'h00: mRe[i] = present && regWdata[i];
            8'h04: mFe[i] = present && regWdata[i];
            8'h80: mIe[i] = present && regWdata[i];
            8'h84: mEe[i] = present && regWdata[i];
            default: ;
          endcase
        end
        mPrev[i] = m2[i];
        m2[i]    = m1[i];
        m1[i]    = extIn[i];
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) begin
      case (a)
        8'h00: v[i] = mRe[i];
        8'h04: v[i] = mFe[i];
        8'h08: v[i] = mSw[i];
        8'h0C: v[i] = mRp[i];
        8'h10: v[i] = mFp[i];
        8'h80: v[i] = mIe[i];
        8'h84: v[i] = mEe[i];
        default: v[i] = 0;
      endcase
    end
    return v;
  endfunction

  function automatic bit modelIrq();
    bit r = 0;
    for (int i = 0; i < 32; i++) if (mIe[i] && (mRp[i] || mFp[i])) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] modelEvt();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = mEvt[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from both clock edges
  always @(posedge clk) begin
    #3;
    if (checkOn) begin
      chk("R7 irqOut", {31'b0, irqOut}, {31'b0, modelIrq()});
      chk("R9 evtOut", evtOut, modelEvt());
      chk("R1 regRdata", regRdata, modelRead(regAddr));
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h80, 8'h84, 8'h40};
    doReset();
    checkOn = 1;

    // R11 reset state of every register
    foreach (addrs[k]) begin rdReg(addrs[k], v); chk("R11 reset value", v, '0); end
    chk("R11 irqOut reset", {31'b0, irqOut}, '0);

    // R6 discovery of present lines
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, v); chk("R6 readback of present lines", v, IMPL);
    wrReg(8'h00, 32'h0);

    // R2 disabled rising edge sets nothing
    @(negedge clk) extIn[3] = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(8'h0C, v); chk("R2 disabled edge ignored", v, '0);
    @(negedge clk) extIn[3] = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R9 enabled rising edge with event pulse
    wrReg(8'h00, 32'h8);
    wrReg(8'h80, 32'h8);
    wrReg(8'h84, 32'h8);
    extIn[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 evt pulse high", evtOut, 32'h8);
    rdReg(8'h0C, v); chk("R2 rise pending", v, 32'h8);
    chk("R9 evt pulse one cycle", evtOut, '0);
    chk("R7 irq with pending", {31'b0, irqOut}, 32'h1);

    // R3 both edges enabled, falling goes to its own register
    wrReg(8'h04, 32'h8);
    extIn[3] = 1'b0;
    repeat (4) @(negedge clk);
    rdReg(8'h10, v); chk("R3 fall pending", v, 32'h8);

    // R4 write 0 keeps, write 1 clears
    wrReg(8'h0C, 32'h0);
    rdReg(8'h0C, v); chk("R4 write zero keeps", v, 32'h8);
    wrReg(8'h0C, 32'h8);
    rdReg(8'h0C, v); chk("R4 write one clears", v, '0);
    rdReg(8'h10, v); chk("R4 other register untouched", v, 32'h8);
    wrReg(8'h10, 32'h8);
    rdReg(8'h10, v); chk("R4 fall cleared", v, '0);
    chk("R7 irq drops", {31'b0, irqOut}, '0);

    // R5 edge and clear on the same clock edge
    @(negedge clk) extIn[3] = 1'b1;
    @(negedge clk);
    wrReg(8'h0C, 32'h8);
    rdReg(8'h0C, v); chk("R5 edge wins over clear", v, 32'h8);
    wrReg(8'h0C, 32'h8);

    // R7 masked pending does not interrupt
    wrReg(8'h80, 32'h0);
    wrReg(8'h08, 32'h80);
    rdReg(8'h0C, v); chk("R8 sw trigger sets pending", v, 32'h80);
    chk("R7 masked line quiet", {31'b0, irqOut}, '0);
    rdReg(8'h08, v); chk("R8 trigger bit held", v, 32'h80);
    wrReg(8'h0C, 32'h80);
    rdReg(8'h08, v); chk("R8 trigger bit self clears", v, '0);

    // R6 absent line cannot be triggered
    wrReg(8'h08, 32'h0200_0000);
    rdReg(8'h0C, v); chk("R6 absent line stays zero", v, '0);

    // R10 unmapped offset
    wrReg(8'h40, 32'hFFFF_FFFF);
    rdReg(8'h40, v); chk("R10 unmapped reads zero", v, '0);
    rdReg(8'h00, v); chk("R10 unmapped write harmless", v, 32'h8);

    // random phase, compared every cycle against the model
    wrReg(8'h00, 32'hFFFF_FFFF);
    wrReg(8'h04, 32'h5555_AAAA);
    wrReg(8'h80, 32'hFFFF_FFFF);
    wrReg(8'h84, 32'hF0F0_F0F0);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      extIn = extIn ^ ($urandom & $urandom & $urandom);
      if ($urandom_range(0, 2) == 0) begin
        regWrEn = 1'b1;
        regAddr = addrs[$urandom_range(0, 7)];
        regWdata = $urandom & $urandom;
      end else begin
        regWrEn = 1'b0;
        regAddr = addrs[$urandom_range(0, 7)];
      end
    end
    @(negedge clk) regWrEn = 1'b0;

    // R11 reset in the middle of activity
    wrReg(8'h08, 32'h1);
    doReset();
    foreach (addrs[k]) begin rdReg(addrs[k], v); chk("R11 mid-run reset", v, '0); end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule